// File: doc/BRIEF.md
# Second-Chance Eviction Victim Selector

This block picks which of N page frames to evict using a second-chance sweep. Every frame carries a single usage flag that is raised whenever the frame is accessed. The frames form a ring, and a pointer travels around that ring in first-in order.

When an eviction is requested, the pointer sweeps forward one frame per clock cycle. Any frame whose flag is raised has its flag lowered and is passed over. The first frame found with a lowered flag becomes the victim. It is reported with a single-cycle grant. Its flag is then raised again, because the frame is about to be refilled. The pointer finishes one position beyond the victim.

A requester raises its request and holds it until it sees the grant. It then drops the request. Usage notifications may arrive in any cycle, including while a sweep is in progress.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset all usage flags are clear, the pointer is at frame 0, the grant is low and the reported victim index is 0, so the first eviction after reset selects frame 0.
- R2: A cycle with `use_valid_i` high raises the usage flag of frame `use_idx_i` at the next clock edge.
- R3: While sweeping, each cycle examines the frame under the pointer. A raised flag is lowered and the pointer moves to the next frame, wrapping from N-1 to 0.
- R4: The first examined frame whose flag is clear is the victim. `evict_gnt_o` is high for exactly one cycle, starting two clock edges after the request is first seen when that frame is the first one examined. `victim_idx_o` carries the victim's index during that cycle.
- R5: After a grant the pointer rests one past the victim and the victim's flag is raised. Back-to-back evictions with no usage therefore return consecutive frames.
- R6: If every flag is raised, the sweep clears all N flags over N cycles and selects the frame where it started, with the grant N+2 edges after the request.
- R7: A usage notification for the frame under the pointer in the cycle that frame's raised flag is being cleared leaves the flag raised, because the set wins over the clear.
- R8: Usage notifications for other frames during a sweep raise their flags and are honoured by the same sweep when the pointer reaches them.
- R9: A new sweep starts only when the request is high while the grant is low. A request held high through a grant starts a fresh sweep afterwards, and two grants are never on consecutive cycles.
- R10: `victim_idx_o` holds the most recent victim until the next grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| use_valid_i | input | 1 | A frame was accessed this cycle |
| use_idx_i | input | IDX_W | Index of the accessed frame |
| evict_req_i | input | 1 | Eviction request, held until grant |
| evict_gnt_o | output | 1 | One-cycle grant, victim valid |
| victim_idx_o | output | IDX_W | Index of the selected victim |

## Verification
The collision that matters is a usage notification landing on the frame the sweep is clearing in that same cycle. The bench provokes it by reading the reference model's pointer on the falling edge and driving a notification to exactly that frame. The outcome is judged later: a following sweep must clear the surviving flag and move past that frame rather than choose it. A long random phase then mixes notifications and requests freely. Every clock is compared against the behavioural model.

// File: rtl/cvs_pkg.sv
package cvs_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SWEEP = 1'b1
  } sweep_state_e;
endpackage

// File: rtl/cvs_ref_bits.sv
module cvs_ref_bits #(
  parameter int N_FRAMES = 16,
  parameter int IDX_W    = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                use_valid_i,
  input  logic [IDX_W-1:0]    use_idx_i,
  input  logic                clr_en_i,
  input  logic                fill_en_i,
  input  logic [IDX_W-1:0]    hand_i,
  output logic [N_FRAMES-1:0] ref_o
);
  for (genvar g = 0; g < N_FRAMES; g++) begin : g_bit
    logic set_hit, clr_hit;
    assign set_hit = (use_valid_i && use_idx_i == IDX_W'(g)) ||
                     (fill_en_i && hand_i == IDX_W'(g));
    assign clr_hit = clr_en_i && hand_i == IDX_W'(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      ref_o[g] <= 1'b0;
      else if (set_hit) ref_o[g] <= 1'b1;  // set beats clear
      else if (clr_hit) ref_o[g] <= 1'b0;
    end
  end

  AST_USE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    use_valid_i |=> ref_o[$past(use_idx_i)]);  // R2
endmodule

// File: rtl/cvs_hand.sv
module cvs_hand #(
  parameter int N_FRAMES = 16,
  parameter int IDX_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [IDX_W-1:0] hand_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_FRAMES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hand_o <= '0;
    else if (adv_i) hand_o <= (hand_o == LAST) ? '0 : hand_o + 1'b1;
  end

  AST_HAND_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hand_o <= LAST);  // R3
endmodule

// File: rtl/cvs_sweep_fsm.sv
module cvs_sweep_fsm
  import cvs_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             cur_ref_i,
  input  logic [IDX_W-1:0] hand_i,
  output logic             clr_en_o,
  output logic             fill_en_o,
  output logic             adv_o,
  output logic             gnt_o,
  output logic [IDX_W-1:0] victim_o
);
  sweep_state_e st_q, st_d;

  always_comb begin
    st_d      = st_q;
    clr_en_o  = 1'b0;
    fill_en_o = 1'b0;
    adv_o     = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (req_i && !gnt_o) st_d = ST_SWEEP;
      ST_SWEEP: begin
        adv_o = 1'b1;
        if (cur_ref_i) clr_en_o = 1'b1;
        else begin
          fill_en_o = 1'b1;
          st_d      = ST_IDLE;
        end
      end
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      gnt_o    <= 1'b0;
      victim_o <= '0;
    end else begin
      st_q  <= st_d;
      gnt_o <= fill_en_o;
      if (fill_en_o) victim_o <= hand_i;
    end
  end

  AST_GNT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_o |=> !gnt_o);  // R9
  AST_VICTIM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gnt_o |-> $stable(victim_o));  // R10
endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int N_FRAMES = 16,
  parameter int IDX_W    = (N_FRAMES > 1) ? $clog2(N_FRAMES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             use_valid_i,
  input  logic [IDX_W-1:0] use_idx_i,
  input  logic             evict_req_i,
  output logic             evict_gnt_o,
  output logic [IDX_W-1:0] victim_idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_FRAMES - 1);

  logic [N_FRAMES-1:0] ref_bits;
  logic [IDX_W-1:0]    hand;
  logic                clr_en, fill_en, adv, cur_ref;

  assign cur_ref = ref_bits[hand];

  cvs_ref_bits #(.N_FRAMES(N_FRAMES), .IDX_W(IDX_W)) u_bits (
    .clk_i, .rst_ni, .use_valid_i, .use_idx_i,
    .clr_en_i(clr_en), .fill_en_i(fill_en), .hand_i(hand), .ref_o(ref_bits)
  );

  cvs_hand #(.N_FRAMES(N_FRAMES), .IDX_W(IDX_W)) u_hand (
    .clk_i, .rst_ni, .adv_i(adv), .hand_o(hand)
  );

  cvs_sweep_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk_i, .rst_ni, .req_i(evict_req_i), .cur_ref_i(cur_ref), .hand_i(hand),
    .clr_en_o(clr_en), .fill_en_o(fill_en), .adv_o(adv),
    .gnt_o(evict_gnt_o), .victim_o(victim_idx_o)
  );

  AST_HAND_PAST_VICTIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_gnt_o |-> hand == ((victim_idx_o == LAST) ? '0 : victim_idx_o + 1'b1));  // R5
  AST_VICTIM_REFILLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_gnt_o |-> ref_bits[victim_idx_o]);  // R5
  AST_CLEAR_ON_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en && !(use_valid_i && use_idx_i == hand)) |=> !ref_bits[$past(hand)]);  // R3
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en && use_valid_i && use_idx_i == hand) |=> ref_bits[$past(hand)]);  // R7
endmodule

// File: tb/tb_clock_victim_sel.sv
`timescale 1ns/1ps
module tb_clock_victim_sel;
  localparam int N = 16;
  localparam int W = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic use_valid_i = 1'b0, evict_req_i = 1'b0;
  logic [W-1:0] use_idx_i = '0;
  logic evict_gnt_o;
  logic [W-1:0] victim_idx_o;

  int checks = 0, fails = 0;
  string cur_tag = "R1";

  always #2.5 clk = ~clk;

  clock_victim_sel #(.N_FRAMES(N)) dut (
    .clk_i(clk), .rst_ni, .use_valid_i, .use_idx_i,
    .evict_req_i, .evict_gnt_o, .victim_idx_o
  );

  // behavioural reference
  bit m_ref[N];
  int m_hand, m_vic;
  bit m_busy, m_gnt;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (m_ref[i]) m_ref[i] = 0;
      m_hand = 0; m_vic = 0; m_busy = 0; m_gnt = 0;
    end else begin
      bit prev_gnt;
      prev_gnt = m_gnt;
      m_gnt = 0;
      if (m_busy) begin
        if (m_ref[m_hand]) m_ref[m_hand] = 0;
        else begin
          m_gnt = 1; m_vic = m_hand; m_ref[m_hand] = 1; m_busy = 0;
        end
        m_hand = (m_hand + 1) % N;
      end else if (evict_req_i && !prev_gnt) m_busy = 1;
      if (use_valid_i) m_ref[use_idx_i] = 1;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_ni) begin
    check({cur_tag, " grant"}, evict_gnt_o, m_gnt);
    check({cur_tag, " victim"}, victim_idx_o, m_vic);
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic use_frame(int f);
    use_valid_i = 1; use_idx_i = W'(f);
    @(negedge clk);
    use_valid_i = 0;
  endtask

  task automatic do_evict(output int vic, output int lat);
    evict_req_i = 1; lat = 0;
    do begin @(negedge clk); lat++; end while (!evict_gnt_o);
    vic = victim_idx_o;
    evict_req_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int v, lat, pulses, back2back;
    bit last_g;
    idle(2);
    check("R1 reset grant", evict_gnt_o, 0);
    check("R1 reset victim", victim_idx_o, 0);
    rst_ni = 1;
    idle(1);

    cur_tag = "R5";
    do_evict(v, lat); check("R1 first victim", v, 0); check("R4 latency", lat, 2);
    idle(1); check("R10 victim held", victim_idx_o, 0);
    do_evict(v, lat); check("R5 next victim", v, 1);
    idle(1);
    do_evict(v, lat); check("R5 next victim", v, 2);
    idle(1);

    cur_tag = "R3";
    use_frame(3); use_frame(4); use_frame(6);
    do_evict(v, lat); check("R2 R3 skip used", v, 5); check("R3 one per cycle", lat, 4);
    idle(1);

    cur_tag = "R6";
    for (int f = 0; f < N; f++) use_frame(f);
    do_evict(v, lat); check("R6 full lap victim", v, 6); check("R6 lap latency", lat, N + 2);
    idle(1);

    // hand now 7; raise 7 and 8, hit 7 while it is being cleared
    cur_tag = "R7";
    use_frame(7); use_frame(8);
    evict_req_i = 1;
    @(negedge clk);
    use_valid_i = 1; use_idx_i = W'(m_hand);
    check("R7 hand aligned", m_hand, 7);
    @(negedge clk);
    use_valid_i = 0;
    while (!evict_gnt_o) @(negedge clk);
    evict_req_i = 0;
    check("R7 first victim", victim_idx_o, 9);
    idle(1);
    for (int f = 10; f < N + 7; f++) use_frame(f % N);
    do_evict(v, lat); check("R7 set survived clear", v, 8);
    idle(1);

    cur_tag = "R8";
    for (int i = 0; i < 3000; i++) begin
      use_valid_i = W'($urandom % 2);
      use_idx_i   = W'($urandom % N);
      if (evict_req_i && evict_gnt_o && ($urandom % 4 != 0)) evict_req_i = 0;
      else if (!evict_req_i && ($urandom % 6 == 0)) evict_req_i = 1;
      @(negedge clk);
    end
    use_valid_i = 0; evict_req_i = 0;
    idle(3);

    cur_tag = "R9";
    pulses = 0; back2back = 0; last_g = 0;
    evict_req_i = 1;
    repeat (40) begin
      @(negedge clk);
      if (evict_gnt_o) pulses++;
      if (evict_gnt_o && last_g) back2back++;
      last_g = evict_gnt_o;
    end
    evict_req_i = 0;
    check("R9 no consecutive grants", back2back, 0);
    check("R9 held request regrants", int'(pulses >= 2), 1);
    idle(3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule